// File: doc/BRIEF.md
# Field-Chained Display Descriptor Fetcher

This block feeds one graphics plane of a display pipeline. It holds a next-node pointer. On every vertical sync strobe it reads a 64-byte plane descriptor (sixteen 32-bit words) from memory at that pointer. When the last word has arrived, it moves the descriptor's active fields into shadow registers, and those registers drive the plane's scanout engine. Each descriptor carries the address of the node to use at the following sync, so the hardware walks a linked list by itself. A top-field node and a bottom-field node that point at each other repeat without any software action. Software brings in a new frame by writing one pointer.

The memory port issues one word read at a time. A request is held with a stable address, and the word is accepted in the cycle where `mem_rvalid` is high. `mem_rdata` must belong to the `mem_addr` presented in that same cycle. The sync strobe carries a field flag, which the block registers and presents. A sticky status vector records underflows reported by the scanout engine, syncs that arrive while a fetch is still running, and rejected misaligned pointers.

Top module: `dnode_fetch`

## Requirements
- R1: After reset, every shadow output is zero, `act_hidden` is 1, `ptr_q` is 0, `field_top` is 0, `status` is 0 and `mem_req` is low.
- R2: A sync sampled while `ptr_q` is nonzero starts a fetch in the next cycle. The fetch requests words at `ptr_q + 4*k` for k = 0 to 15, in increasing order. `mem_req` stays high until the sixteenth word is accepted.
- R3: The shadow outputs change together, and only in the cycle after the sixteenth word is accepted. The field map by byte offset is: control 0x00 to `act_ctl`, first line/pixel 0x0C to `act_vp_start`, last line/pixel 0x10 to `act_vp_end`, pixel memory pointer 0x14 to `act_base`, pitch 0x18 to `act_pitch`, size 0x1C to `act_size`. All other words have no effect on the outputs.
- R4: `act_size` holds the height in bits 31:16 and the width in bits 15:0. A height above 2160 is clamped to 2160 and a width above 3840 is clamped to 3840.
- R5: `act_hidden` is 1 when bit 1 or bit 0 of the word at offset 0x34 is set. Other bits of that word do not affect it.
- R6: When a fetch completes, `ptr_q` takes the word at offset 0x24 (the link to the next node), unless R7 applies.
- R7: A pointer write changes `ptr_q` in the next cycle and is used only at the next sync. It never changes the shadow outputs. A write accepted after a fetch has started wins over that fetch's link.
- R8: A pointer whose bits 3:0 are not zero is rejected and sets `status[2]`. A rejected write leaves `ptr_q` unchanged. A rejected link from a fetched node sets `ptr_q` to 0.
- R9: A sync sampled while `ptr_q` is 0 starts no fetch.
- R10: A sync that arrives during a fetch sets `status[1]` and abandons the partial node, and the shadow outputs keep their previous values. The fetch restarts at word 0 of the current `ptr_q` when that pointer is nonzero.
- R11: A cycle with `scan_underflow` high sets `status[0]`. All status bits stay set until reset.
- R12: `field_top` takes the value of `vsync_top` that was sampled with each sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | One-cycle vertical sync strobe |
| vsync_top | input | 1 | Field flag with the strobe, 1 = top field |
| ptr_we | input | 1 | Next-node pointer write enable |
| ptr_wdata | input | AW | Next-node pointer write value |
| scan_underflow | input | 1 | Underflow report from the scanout engine |
| mem_req | output | 1 | Word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read word accepted this cycle |
| mem_rdata | input | 32 | Read word |
| ptr_q | output | AW | Current next-node pointer |
| act_ctl | output | 32 | Active control word |
| act_vp_start | output | 32 | First output line (31:16) and pixel (15:0) |
| act_vp_end | output | 32 | Last output line (31:16) and pixel (15:0) |
| act_base | output | 32 | Pixel memory pointer |
| act_pitch | output | 32 | Line pitch in bytes |
| act_size | output | 32 | Clamped height (31:16) and width (15:0) |
| act_hidden | output | 1 | Plane excluded from the mixer |
| field_top | output | 1 | Field flag of the latest sync |
| status | output | 3 | Sticky flags: 0 underflow, 1 late fetch, 2 misaligned pointer |

## Verification
The hardest case to reach is a sync that lands in the middle of a fetch. At full memory speed a fetch takes only sixteen cycles, which is far shorter than any sync interval. The bench therefore has its memory responder answer one request in four, which stretches the fetch, and it strobes sync partway through. It then checks that the old shadow set survives, that the late flag rises and that the fetch restarts from word 0. A second race that is hard to reach is a pointer write placed while a fetch is in flight. The bench times this write inside the sixteen-word window to show that it overrides the node's own link.

// File: rtl/dnode_pkg.sv
`timescale 1ns/1ps
package dnode_pkg;
    localparam int WORD_W     = 32;
    localparam int NODE_WORDS = 16;
    localparam int IDX_W      = $clog2(NODE_WORDS);

    // word index of each used descriptor field (byte offset / 4)
    localparam int WI_CTL   = 0;
    localparam int WI_VPS   = 3;
    localparam int WI_VPE   = 4;
    localparam int WI_BASE  = 5;
    localparam int WI_PITCH = 6;
    localparam int WI_SIZE  = 7;
    localparam int WI_LINK  = 9;
    localparam int WI_PPT   = 13;

    // status bit positions
    localparam int ST_UFL   = 0;
    localparam int ST_LATE  = 1;
    localparam int ST_ALIGN = 2;
    localparam int ST_W     = 3;

    typedef struct packed {
        logic [WORD_W-1:0] ctl;
        logic [WORD_W-1:0] vp_start;
        logic [WORD_W-1:0] vp_end;
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] pitch;
        logic [WORD_W-1:0] size;
        logic              hidden;
    } plane_t;
endpackage

// File: rtl/dnode_seq.sv
`timescale 1ns/1ps
// Fetch sequencer: walks the sixteen words of one node per sync.
module dnode_seq import dnode_pkg::*; #(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync,
    input  logic [AW-1:0]    ptr,
    input  logic             mem_rvalid,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             acc,
    output logic [IDX_W-1:0] acc_idx,
    output logic             start,
    output logic             done,
    output logic             late
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NODE_WORDS - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]    base;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        start = 1'b0;
        done  = 1'b0;
        late  = 1'b0;
        acc   = 1'b0;
        if (vsync) begin
            late    = s_q.busy;
            s_d.idx = '0;
            if (ptr != '0) begin
                s_d.busy = 1'b1;
                s_d.base = ptr;
                start    = 1'b1;
            end else begin
                s_d.busy = 1'b0;
            end
        end else if (s_q.busy && mem_rvalid) begin
            acc = 1'b1;
            if (s_q.idx == LAST) begin
                s_d.busy = 1'b0;
                done     = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_req  = s_q.busy;
    assign mem_addr = s_q.base + AW'({s_q.idx, 2'b00});
    assign acc_idx  = s_q.idx;
endmodule

// File: rtl/dnode_ptr.sv
`timescale 1ns/1ps
// Next-node pointer: software writes, link reload, alignment screening.
module dnode_ptr #(
    parameter int AW      = 32,
    parameter int ALIGN_B = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          start,
    input  logic          done,
    input  logic [AW-1:0] link,
    output logic [AW-1:0] ptr,
    output logic          bad
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          pend;
    } ptr_t;

    ptr_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        bad = 1'b0;
        if (start) p_d.pend = 1'b0;
        if (done && !p_q.pend) begin
            if (link[ALIGN_B-1:0] != '0) begin
                p_d.ptr = '0;
                bad     = 1'b1;
            end else begin
                p_d.ptr = link;
            end
        end
        if (wr_en) begin
            if (wr_data[ALIGN_B-1:0] == '0) begin
                p_d.ptr  = wr_data;
                p_d.pend = 1'b1;
            end else begin
                bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign ptr = p_q.ptr;
endmodule

// File: rtl/dnode_shadow.sv
`timescale 1ns/1ps
// Staging of incoming words and atomic commit to the active set.
module dnode_shadow import dnode_pkg::*; #(
    parameter int MAX_W = 3840,
    parameter int MAX_H = 2160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [WORD_W-1:0] rdata,
    input  logic              done,
    output plane_t            act,
    output logic [WORD_W-1:0] link
);
    localparam int HW = WORD_W / 2;
    localparam logic [HW-1:0] MAX_WV = HW'(MAX_W);
    localparam logic [HW-1:0] MAX_HV = HW'(MAX_H);

    typedef struct packed {
        plane_t            stg;
        logic [WORD_W-1:0] lnk;
        plane_t            act;
    } sh_t;

    sh_t s_d, s_q;
    logic [HW-1:0] w_clamp, h_clamp;

    always_comb begin
        w_clamp = (rdata[HW-1:0] > MAX_WV) ? MAX_WV : rdata[HW-1:0];
        h_clamp = (rdata[WORD_W-1:HW] > MAX_HV) ? MAX_HV : rdata[WORD_W-1:HW];
        s_d = s_q;
        if (acc) begin
            case (acc_idx)
                IDX_W'(WI_CTL):   s_d.stg.ctl      = rdata;
                IDX_W'(WI_VPS):   s_d.stg.vp_start = rdata;
                IDX_W'(WI_VPE):   s_d.stg.vp_end   = rdata;
                IDX_W'(WI_BASE):  s_d.stg.base     = rdata;
                IDX_W'(WI_PITCH): s_d.stg.pitch    = rdata;
                IDX_W'(WI_SIZE):  s_d.stg.size     = {h_clamp, w_clamp};
                IDX_W'(WI_LINK):  s_d.lnk          = rdata;
                IDX_W'(WI_PPT):   s_d.stg.hidden   = |rdata[1:0];
                default: ;
            endcase
        end
        if (done) s_d.act = s_q.stg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.stg.hidden <= 1'b1;
            s_q.act.hidden <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign act  = s_q.act;
    assign link = s_q.lnk;
endmodule

// File: rtl/dnode_fetch.sv
`timescale 1ns/1ps
module dnode_fetch import dnode_pkg::*; #(
    parameter int AW      = 32,
    parameter int ALIGN_B = 4,
    parameter int MAX_W   = 3840,
    parameter int MAX_H   = 2160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              vsync_top,
    input  logic              ptr_we,
    input  logic [AW-1:0]     ptr_wdata,
    input  logic              scan_underflow,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [AW-1:0]     ptr_q,
    output logic [WORD_W-1:0] act_ctl,
    output logic [WORD_W-1:0] act_vp_start,
    output logic [WORD_W-1:0] act_vp_end,
    output logic [WORD_W-1:0] act_base,
    output logic [WORD_W-1:0] act_pitch,
    output logic [WORD_W-1:0] act_size,
    output logic              act_hidden,
    output logic              field_top,
    output logic [ST_W-1:0]   status
);
    logic             acc, start, done, late, bad;
    logic [IDX_W-1:0] acc_idx;
    plane_t           act;
    logic [WORD_W-1:0] link;

    dnode_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .ptr(ptr_q),
        .mem_rvalid(mem_rvalid), .mem_req(mem_req), .mem_addr(mem_addr),
        .acc(acc), .acc_idx(acc_idx), .start(start), .done(done), .late(late)
    );

    dnode_ptr #(.AW(AW), .ALIGN_B(ALIGN_B)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_en(ptr_we), .wr_data(ptr_wdata),
        .start(start), .done(done), .link(link[AW-1:0]), .ptr(ptr_q), .bad(bad)
    );

    dnode_shadow #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_sh (
        .clk(clk), .rst_n(rst_n), .acc(acc), .acc_idx(acc_idx),
        .rdata(mem_rdata), .done(done), .act(act), .link(link)
    );

    typedef struct packed {
        logic            field_top;
        logic [ST_W-1:0] stat;
    } top_t;

    top_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (vsync)          t_d.field_top      = vsync_top;
        if (scan_underflow) t_d.stat[ST_UFL]   = 1'b1;
        if (late)           t_d.stat[ST_LATE]  = 1'b1;
        if (bad)            t_d.stat[ST_ALIGN] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign act_ctl      = act.ctl;
    assign act_vp_start = act.vp_start;
    assign act_vp_end   = act.vp_end;
    assign act_base     = act.base;
    assign act_pitch    = act.pitch;
    assign act_size     = act.size;
    assign act_hidden   = act.hidden;
    assign field_top    = t_q.field_top;
    assign status       = t_q.stat;
endmodule

// File: rtl/dnode_fetch_chk.sv
`timescale 1ns/1ps
module dnode_fetch_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vsync,
    input logic          vsync_top,
    input logic          scan_underflow,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rvalid,
    input logic [AW-1:0] ptr_q,
    input logic [31:0]   act_ctl,
    input logic [31:0]   act_base,
    input logic [31:0]   act_size,
    input logic          act_hidden,
    input logic          field_top,
    input logic [2:0]    status
);
    p_fetch_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && ptr_q != '0) |=> (mem_req && mem_addr == $past(ptr_q)));

    p_word_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_commit_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mem_rvalid) |=> $stable({act_ctl, act_base, act_size, act_hidden}));

    p_ptr_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q[3:0] == 4'h0);

    p_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && ptr_q == '0) |=> !mem_req);

    p_late_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && mem_req) |=> status[1]);

    p_ufl_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        scan_underflow |=> status[0]);

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(status[0]) && !$fell(status[1]) && !$fell(status[2]));

    p_field_r12: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (field_top == $past(vsync_top)));
endmodule

bind dnode_fetch dnode_fetch_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .vsync_top(vsync_top),
    .scan_underflow(scan_underflow), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .ptr_q(ptr_q), .act_ctl(act_ctl),
    .act_base(act_base), .act_size(act_size), .act_hidden(act_hidden),
    .field_top(field_top), .status(status)
);

// File: tb/sim_dnode_fetch.sv
`timescale 1ns/1ps
module sim_dnode_fetch;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync = 1'b0, vsync_top = 1'b0;
    logic        ptr_we = 1'b0;
    logic [31:0] ptr_wdata = '0;
    logic        scan_underflow = 1'b0;
    logic        mem_req, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic [31:0] ptr_q, act_ctl, act_vp_start, act_vp_end, act_base, act_pitch, act_size;
    logic        act_hidden, field_top;
    logic [2:0]  status;

    int n_chk = 0, n_fail = 0;
    bit ended = 0;

    always #(CLK_PER/2) clk = ~clk;

    dnode_fetch u0 (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .vsync_top(vsync_top),
        .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .scan_underflow(scan_underflow),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .ptr_q(ptr_q), .act_ctl(act_ctl),
        .act_vp_start(act_vp_start), .act_vp_end(act_vp_end), .act_base(act_base),
        .act_pitch(act_pitch), .act_size(act_size), .act_hidden(act_hidden),
        .field_top(field_top), .status(status)
    );

    // ---------------- memory responder ----------------
    logic [31:0] memw [0:255];
    bit          slow = 0;
    int          scnt = 0;

    always @(negedge clk) begin
        scnt++;
        if (mem_req && (!slow || (scnt % 4) == 0)) begin
            mem_rvalid = 1'b1;
            mem_rdata  = memw[mem_addr[9:2]];
        end else begin
            mem_rvalid = 1'b0;
            mem_rdata  = 32'hx;
        end
    end

    task automatic mk_node(input logic [31:0] a, ctl, vps, vpe, pml, pmp, sz, nxt, ppt);
        for (int k = 0; k < 16; k++) memw[a[9:2] + k] = 32'hDEAD_0000 | k;
        memw[a[9:2] + 0]  = ctl;
        memw[a[9:2] + 3]  = vps;
        memw[a[9:2] + 4]  = vpe;
        memw[a[9:2] + 5]  = pml;
        memw[a[9:2] + 6]  = pmp;
        memw[a[9:2] + 7]  = sz;
        memw[a[9:2] + 9]  = nxt;
        memw[a[9:2] + 13] = ppt;
    endtask

    // ---------------- behavioural reference ----------------
    logic [31:0] m_stage [0:15];
    logic [31:0] m_ptr, m_fbase, m_ctl, m_vps, m_vpe, m_base, m_pitch, m_size;
    logic        m_hidden, m_field, m_busy, m_pend;
    logic [2:0]  m_stat;
    int          m_idx;

    function automatic logic [31:0] clampsz(input logic [31:0] s);
        logic [15:0] w, h;
        w = (s[15:0]  > 16'd3840) ? 16'd3840 : s[15:0];
        h = (s[31:16] > 16'd2160) ? 16'd2160 : s[31:16];
        return {h, w};
    endfunction

    always @(posedge clk) begin : mdl
        logic [31:0] old_ptr;
        bit dn;
        if (!rst_n) begin
            m_ptr = 0; m_fbase = 0; m_ctl = 0; m_vps = 0; m_vpe = 0; m_base = 0;
            m_pitch = 0; m_size = 0; m_hidden = 1; m_field = 0; m_busy = 0;
            m_pend = 0; m_stat = 0; m_idx = 0;
        end else begin
            old_ptr = m_ptr;
            dn = 0;
            if (scan_underflow) m_stat[0] = 1;
            if (vsync && m_busy) m_stat[1] = 1;
            if (!vsync && m_busy && mem_rvalid) begin
                m_stage[m_idx] = mem_rdata;
                if (m_idx == 15) begin
                    dn = 1; m_busy = 0;
                    m_ctl = m_stage[0]; m_vps = m_stage[3]; m_vpe = m_stage[4];
                    m_base = m_stage[5]; m_pitch = m_stage[6];
                    m_size = clampsz(m_stage[7]);
                    m_hidden = (m_stage[13][1:0] != 2'b00);
                end else m_idx++;
            end
            if (dn && !m_pend) begin
                if (m_stage[9][3:0] != 0) begin m_ptr = 0; m_stat[2] = 1; end
                else m_ptr = m_stage[9];
            end
            if (vsync && old_ptr != 0) m_pend = 0;
            if (ptr_we) begin
                if (ptr_wdata[3:0] != 0) m_stat[2] = 1;
                else begin m_ptr = ptr_wdata; m_pend = 1; end
            end
            if (vsync) begin
                m_field = vsync_top;
                m_idx = 0;
                if (old_ptr != 0) begin m_busy = 1; m_fbase = old_ptr; end
                else m_busy = 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare every cycle, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PER/4);
        if (rst_n && !ended) begin
            chk("R2", "mem_req", {31'd0, mem_req}, {31'd0, m_busy});
            if (m_busy) chk("R2", "mem_addr", mem_addr, m_fbase + 4 * m_idx);
            chk("R3", "act_ctl", act_ctl, m_ctl);
            chk("R3", "act_vp_start", act_vp_start, m_vps);
            chk("R3", "act_vp_end", act_vp_end, m_vpe);
            chk("R3", "act_base", act_base, m_base);
            chk("R3", "act_pitch", act_pitch, m_pitch);
            chk("R4", "act_size", act_size, m_size);
            chk("R5", "act_hidden", {31'd0, act_hidden}, {31'd0, m_hidden});
            chk("R6", "ptr_q", ptr_q, m_ptr);
            chk("R12", "field_top", {31'd0, field_top}, {31'd0, m_field});
            chk("R11", "status", {29'd0, status}, {29'd0, m_stat});
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sync(input logic top);
        @(negedge clk); vsync = 1'b1; vsync_top = top;
        @(negedge clk); vsync = 1'b0;
    endtask

    task automatic wr_ptr(input logic [31:0] v);
        @(negedge clk); ptr_we = 1'b1; ptr_wdata = v;
        @(negedge clk); ptr_we = 1'b0;
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PER * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        mk_node(32'h040, 32'h8000_0005, 32'h0010_0020, 32'h01FF_02FF, 32'h1000_0000,
                32'h0000_0A00, 32'h0100_0200, 32'h0000_0080, 32'h0);
        mk_node(32'h080, 32'h8000_0105, 32'h0011_0020, 32'h0200_02FF, 32'h1000_0A00,
                32'h0000_0A00, 32'h1000_1000, 32'h0000_0040, 32'h2);
        mk_node(32'h0C0, 32'h0000_0007, 32'h0, 32'h0001_0001, 32'h2000_0000,
                32'h0000_0040, 32'h0002_0002, 32'h0000_00C8, 32'h4);
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1", "reset ptr", ptr_q, 0);
        chk("R1", "reset hidden", {31'd0, act_hidden}, 1);
        chk("R1", "reset status", {29'd0, status}, 0);
        chk("R1", "reset req", {31'd0, mem_req}, 0);
        chk("R1", "reset ctl", act_ctl, 0);
        // R9 sync with empty pointer
        sync(1'b1); tick(2);
        chk("R9", "no fetch on zero ptr", {31'd0, mem_req}, 0);
        // R7 write takes effect, shadows untouched
        wr_ptr(32'h040); tick(1);
        chk("R7", "ptr after write", ptr_q, 32'h040);
        chk("R7", "shadow after write", act_ctl, 0);
        // top field node A
        sync(1'b1); tick(20);
        chk("R3", "A ctl", act_ctl, 32'h8000_0005);
        chk("R3", "A base", act_base, 32'h1000_0000);
        chk("R6", "A link", ptr_q, 32'h080);
        chk("R12", "top field", {31'd0, field_top}, 1);
        // bottom field node B: hidden, oversize
        sync(1'b0); tick(20);
        chk("R5", "B hidden", {31'd0, act_hidden}, 1);
        chk("R4", "B size clamp", act_size, 32'h0870_0F00);
        chk("R6", "B link", ptr_q, 32'h040);
        chk("R12", "bottom field", {31'd0, field_top}, 0);
        // splice C during fetch of A
        sync(1'b1); tick(5);
        wr_ptr(32'h0C0);
        chk("R7", "shadow kept during splice", act_ctl, 32'h8000_0105);
        tick(15);
        chk("R7", "write beats link", ptr_q, 32'h0C0);
        chk("R3", "A reloaded", act_ctl, 32'h8000_0005);
        // node C with misaligned link, ppt bit 2 only
        sync(1'b0); tick(20);
        chk("R8", "bad link zeroes ptr", ptr_q, 0);
        chk("R8", "align flag", {31'd0, status[2]}, 1);
        chk("R5", "ppt bit2 not hiding", {31'd0, act_hidden}, 0);
        sync(1'b1); tick(2);
        chk("R9", "chain ended", {31'd0, mem_req}, 0);
        // late fetch
        wr_ptr(32'h040);
        slow = 1;
        sync(1'b1); tick(20);
        chk("R10", "slow fetch busy", {31'd0, mem_req}, 1);
        sync(1'b0);
        chk("R10", "restart addr", mem_addr, 32'h040);
        chk("R10", "late flag", {31'd0, status[1]}, 1);
        chk("R10", "shadow kept", act_ctl, 32'h0000_0007);
        slow = 0;
        tick(25);
        chk("R10", "restart completes", act_ctl, 32'h8000_0005);
        // underflow
        @(negedge clk); scan_underflow = 1'b1;
        @(negedge clk); scan_underflow = 1'b0;
        chk("R11", "underflow flag", {31'd0, status[0]}, 1);
        tick(3);
        chk("R11", "underflow sticky", {31'd0, status[0]}, 1);
        // misaligned write ignored
        wr_ptr(32'h084); tick(1);
        chk("R8", "misaligned write ignored", ptr_q, 32'h080);
        tick(3);
        finish_run();
    end
endmodule